// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external static RAM of 65,536 words by 16 bits that has no clock of its own. The host presents one request at a time on a request/ready handshake. The request carries an address, write data, a read/write flag and a byte-enable bit for each byte lane. The controller turns each request into a timed pin sequence on the memory side. That side has a 16-bit address, a pair of chip selects of opposite polarity, active-low output enable, write enable and byte strobes, and a shared three-state data bus.

Access time is met by holding each access for a whole number of clock cycles. That number is derived at elaboration from the memory speed grade (35, 45 or 55 ns) and the clock period. Whenever no transaction is in progress, the controller parks the memory in standby. Both chip selects are deasserted and both byte strobes are high. The controller's bus driver is off and output enable is high.

The host raises `host_req` with stable fields and keeps them until `host_ready` pulses. In the cycle after that pulse it drops the request or replaces it with the next one. Requests are sampled only while the controller is idle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the memory pins show standby: `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_ub_n`=1, `mem_lb_n`=1, `host_ready`=0.
- R2: The access length is WAIT = max(1, ceil(ACCESS_NS / CLK_NS)) cycles, and ACCESS_NS is limited to 35, 45 or 55. With a 20 ns clock and 55 ns parts this gives 3.
- R3: In every cycle outside a transaction, the memory is deselected (`mem_cs_n`=1, `mem_cs`=0) and both byte strobes are high.
- R4: A read selects the memory for exactly WAIT cycles, starting the cycle after the request is sampled. During those cycles `mem_oe_n`=0 and `mem_we_n`=1, the request address is on `mem_addr`, and each strobe is low only for an enabled lane. Enable bit 1 drives `mem_ub_n` (data bits 15:8) and bit 0 drives `mem_lb_n` (bits 7:0).
- R5: `host_ready` is high for exactly one cycle per transaction, and the memory is in standby in that cycle. For a read, `host_rdata` in that cycle holds the bus value captured at the end of the last access cycle, with disabled lanes forced to zero. For a write, `host_rdata` is zero.
- R6: A write starts with one setup cycle. In it the memory is selected with the address and strobes valid, `mem_we_n`=1, `mem_oe_n`=1, and the write data already driven.
- R7: `mem_we_n` then stays low for exactly WAIT cycles, and the controller drives the write data on `mem_dq` throughout.
- R8: In the cycle after `mem_we_n` rises, the address, the chip selects and the driven data are unchanged.
- R9: The controller drives `mem_dq` only in write setup, pulse and hold cycles, and never while `mem_oe_n` is low.
- R10: After a read's last access cycle, the next cycle has `mem_oe_n` high and the controller's driver off. This holds even when a write request is already waiting.
- R11: A request with both byte enables clear completes with `host_ready` in the next cycle and `host_rdata`=0. It never selects the memory and leaves memory contents unchanged.
- R12: A request presented during the ready cycle is not sampled there. It is sampled in the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Request valid, held until ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_ready |
| mem_addr | output | 16 | Memory word address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_dq | inout | 16 | Shared three-state data bus |

## Verification
A wrong state or timer value appears on the memory pins at the very next clock. It shows as a select, output-enable or write-enable edge one cycle early or late, or as a ready pulse out of place. Every pin is compared against an expected pattern on every cycle, so such a slip is reported in the cycle it happens. A wrong lane mask or a missed capture shows only later, as wrong read data in a ready cycle. The bench therefore reads back each address after partial-byte writes, so that corrupted bytes are also caught.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_DONE
  } ctrl_state_e;

  // Whole clock cycles needed to cover the access time, never fewer than one.
  function automatic int unsigned wait_cycles(int unsigned access_ns, int unsigned clk_ns);
    int unsigned n;
    n = (access_ns + clk_ns - 1) / clk_ns;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);

  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_en = load | (dec & ~zero);
    if (load) cnt_d = LOAD_VAL;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LOAD_VAL); // R2

endmodule

// File: rtl/sram_data_lanes.sv
module sram_data_lanes #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              sel_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  strobe_n_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  strobe_n_d;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign masked[l*8 +: 8] = be_q[l] ? dq_in[l*8 +: 8] : 8'h00;
  end

  always_comb begin
    strobe_n_d = sel_d ? ~(accept ? req_be : be_q) : '1;
    rdata_en   = accept | capture;
    rdata_d    = capture ? masked : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_n_q <= '1;
    else        strobe_n_q <= strobe_n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 3,
  parameter int unsigned LANES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic             tmr_dec,
  output logic             accept,
  output logic             capture,
  output logic             sel_d,
  output logic             cs_n_q,
  output logic             cs_q,
  output logic             oe_n_q,
  output logic             we_n_q,
  output logic             drv_q,
  output logic             ready_q
);

  localparam int unsigned WCNT_W = $clog2(WAIT_CYC + 2);

  ctrl_state_e state_q, state_d;
  logic        oe_n_d, we_n_d, drv_d, ready_d;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_be == '0) begin
            state_d = ST_DONE;
          end else if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_WAIT;
            tmr_load = 1'b1;
          end
        end
      end
      ST_RD_WAIT: begin
        if (tmr_zero) begin
          capture = 1'b1;
          state_d = ST_DONE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
      end
      ST_WR_PULSE: begin
        if (tmr_zero) state_d = ST_WR_HOLD;
        else          tmr_dec = 1'b1;
      end
      ST_WR_HOLD: state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Pin levels follow the state being entered, so every pin leaves a flop.
  always_comb begin
    sel_d   = (state_d == ST_RD_WAIT) || (state_d == ST_WR_SETUP) ||
              (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    oe_n_d  = (state_d != ST_RD_WAIT);
    we_n_d  = (state_d != ST_WR_PULSE);
    drv_d   = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
              (state_d == ST_WR_HOLD);
    ready_d = (state_d == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      cs_q    <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= ~sel_d;
      cs_q    <= sel_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      drv_q   <= drv_d;
      ready_q <= ready_d;
    end
  end

  // Checker-side length of the current write-enable low pulse.
  logic [WCNT_W-1:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       we_low_cnt <= '0;
    else if (!we_n_q) we_low_cnt <= we_low_cnt + 1'b1;
    else              we_low_cnt <= '0;
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ready_q |=> !ready_q); // R5
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE) |-> (cs_n_q && !cs_q && oe_n_q && !drv_q)); // R3
  AST_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n) (accept && req_be == '0) |=> (ready_q && cs_n_q && !cs_q)); // R11
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n_q) |-> (we_low_cnt == WCNT_W'(WAIT_CYC))); // R7

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned ACCESS_NS = 55,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LANES     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int unsigned WAIT_CYC = sram_ctrl_pkg::wait_cycles(ACCESS_NS, CLK_NS);

  if (ACCESS_NS != 35 && ACCESS_NS != 45 && ACCESS_NS != 55) begin : g_grade_chk
    $error("ACCESS_NS must be one of 35, 45, 55");
  end
  if (LANES != 2) begin : g_lane_chk
    $error("two byte lanes are required");
  end

  logic              rst_sync_n;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic              accept, capture, sel_d;
  logic              drv_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  strobe_n_q;

  sram_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  sram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (tmr_load),
    .dec   (tmr_dec),
    .zero  (tmr_zero)
  );

  sram_access_fsm #(.WAIT_CYC(WAIT_CYC), .LANES(LANES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (host_req),
    .req_write (host_write),
    .req_be    (host_be),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_dec   (tmr_dec),
    .accept    (accept),
    .capture   (capture),
    .sel_d     (sel_d),
    .cs_n_q    (mem_cs_n),
    .cs_q      (mem_cs),
    .oe_n_q    (mem_oe_n),
    .we_n_q    (mem_we_n),
    .drv_q     (drv_q),
    .ready_q   (host_ready)
  );

  sram_data_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .capture    (capture),
    .sel_d      (sel_d),
    .req_addr   (host_addr),
    .req_wdata  (host_wdata),
    .req_be     (host_be),
    .dq_in      (mem_dq),
    .addr_q     (mem_addr),
    .wdata_q    (wdata_q),
    .strobe_n_q (strobe_n_q),
    .rdata_q    (host_rdata)
  );

  assign mem_ub_n = strobe_n_q[1];
  assign mem_lb_n = strobe_n_q[0];
  assign mem_dq   = drv_q ? wdata_q : {DATA_W{1'bz}};

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_sync_n) !(drv_q && !mem_oe_n)); // R9
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_sync_n) $rose(mem_oe_n) |-> !drv_q); // R10
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_sync_n) $fell(mem_we_n) |-> ($past(!mem_cs_n && mem_cs && mem_oe_n && drv_q) && $stable(mem_addr))); // R6
  AST_WE_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n) !mem_we_n |-> (drv_q && !mem_cs_n && mem_cs)); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n) $rose(mem_we_n) |-> (drv_q && !mem_cs_n && $stable(mem_addr) && $stable(wdata_q))); // R8
  AST_STROBE_STANDBY: assert property (@(posedge clk) disable iff (!rst_sync_n) mem_cs_n |-> (mem_ub_n && mem_lb_n)); // R3

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int CLK_NS    = 20;
  localparam int ACCESS_NS = 55;
  localparam int W_CALC    = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int W         = (W_CALC < 1) ? 1 : W_CALC; // R2

  localparam logic [6:0] PINS_IDLE = 7'b0101111; // {ready,cs_n,cs,oe_n,we_n,ub_n,lb_n}
  localparam logic [6:0] PINS_DONE = 7'b1101111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_write;
  logic [15:0] host_addr, host_wdata;
  logic [1:0]  host_be;
  logic        host_ready;
  logic [15:0] host_rdata, mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  wire  [15:0] mem_dq;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_on = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .ACCESS_NS(ACCESS_NS)) u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq(mem_dq)
  );

  // Behavioural memory on the pins.
  logic [15:0] mdl_mem [int unsigned];
  logic [15:0] mdl_word = 16'h0;
  logic        mdl_rd;

  function automatic logic [15:0] mdl_get(int unsigned a);
    return mdl_mem.exists(a) ? mdl_mem[a] : 16'h0;
  endfunction

  assign mdl_rd = (mem_cs_n === 1'b0) && (mem_cs === 1'b1) && (mem_we_n === 1'b1) && (mem_oe_n === 1'b0);
  assign mem_dq[15:8] = (mdl_rd && mem_ub_n === 1'b0) ? mdl_word[15:8] : 8'hzz;
  assign mem_dq[7:0]  = (mdl_rd && mem_lb_n === 1'b0) ? mdl_word[7:0]  : 8'hzz;

  always @(negedge clk) mdl_word <= mdl_get(32'(mem_addr));

  always @(posedge mem_we_n) begin
    logic [15:0] w;
    if (mem_cs_n === 1'b0 && mem_cs === 1'b1) begin
      w = mdl_get(32'(mem_addr));
      if (mem_ub_n === 1'b0) w[15:8] = mem_dq[15:8];
      if (mem_lb_n === 1'b0) w[7:0]  = mem_dq[7:0];
      mdl_mem[32'(mem_addr)] = w;
    end
  end

  // Reference: requirement-level shadow of memory contents.
  logic [15:0] shadow [int unsigned];
  function automatic logic [15:0] shadow_get(int unsigned a);
    return shadow.exists(a) ? shadow[a] : 16'h0;
  endfunction

  typedef struct {
    logic [6:0]  pins;
    bit          chk_addr;
    logic [15:0] addr;
    bit          chk_dq;
    logic [15:0] dq;
    bit          chk_rd;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t mk(logic [6:0] p, string t);
    exp_t e;
    e.pins = p; e.chk_addr = 0; e.addr = '0; e.chk_dq = 0; e.dq = '0;
    e.chk_rd = 0; e.rd = '0; e.tag = t;
    return e;
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (mon_on && !finished) begin
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else                   e = mk(PINS_IDLE, "R3");
      check(e.tag, "pins", {9'b0, host_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, {9'b0, e.pins});
      if (e.chk_addr) check(e.tag, "addr", mem_addr, e.addr);
      if (e.chk_dq)   check(e.tag, "dq", mem_dq, e.dq);
      if (e.chk_rd)   check(e.tag, "rdata", host_rdata, e.rd);
    end
  end

  task automatic do_txn(bit wr, logic [15:0] a, logic [15:0] d, logic [1:0] be, bit b2b);
    exp_t e;
    logic [15:0] cur, expd;
    if (!b2b) begin @(negedge clk); #1; end
    else exp_q.push_back(mk(PINS_IDLE, "R12"));
    host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d; host_be = be;
    cur = shadow_get(32'(a));
    if (be == 2'b00) begin
      e = mk(PINS_DONE, "R11"); e.chk_rd = 1; e.rd = 16'h0; exp_q.push_back(e);
    end else if (!wr) begin
      expd = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
      for (int i = 0; i < W; i++) begin
        e = mk({4'b0010, 1'b1, ~be}, "R4,R2"); e.chk_addr = 1; e.addr = a; exp_q.push_back(e);
      end
      e = mk(PINS_DONE, "R5,R10"); e.chk_rd = 1; e.rd = expd; exp_q.push_back(e);
    end else begin
      e = mk({4'b0011, 1'b1, ~be}, "R6"); e.chk_addr = 1; e.addr = a; e.chk_dq = 1; e.dq = d; exp_q.push_back(e);
      for (int i = 0; i < W; i++) begin
        e = mk({4'b0011, 1'b0, ~be}, "R7,R9"); e.chk_addr = 1; e.addr = a; e.chk_dq = 1; e.dq = d; exp_q.push_back(e);
      end
      e = mk({4'b0011, 1'b1, ~be}, "R8"); e.chk_addr = 1; e.addr = a; e.chk_dq = 1; e.dq = d; exp_q.push_back(e);
      e = mk(PINS_DONE, "R5"); e.chk_rd = 1; e.rd = 16'h0; exp_q.push_back(e);
      if (be[1]) cur[15:8] = d[15:8];
      if (be[0]) cur[7:0]  = d[7:0];
      shadow[32'(a)] = cur;
    end
    do @(negedge clk); while (!host_ready);
    #1 host_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; host_req = 1'b0; host_write = 1'b0;
    host_addr = '0; host_wdata = '0; host_be = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset pins", {9'b0, host_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, {9'b0, PINS_IDLE});
    rst_n = 1'b1;
    mon_on = 1;
    repeat (4) @(negedge clk);
    check("R1", "pins after release", {9'b0, host_ready, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, {9'b0, PINS_IDLE});

    do_txn(1, 16'h0010, 16'h1234, 2'b11, 0);   // full write
    do_txn(0, 16'h0010, 16'h0000, 2'b11, 0);   // full read
    do_txn(1, 16'h0010, 16'hABCD, 2'b10, 0);   // upper lane only
    do_txn(0, 16'h0010, 16'h0000, 2'b01, 0);   // lower lane read
    do_txn(0, 16'h0010, 16'h0000, 2'b10, 0);   // upper lane read
    do_txn(1, 16'h0010, 16'hFFFF, 2'b00, 0);   // R11 empty write
    do_txn(0, 16'h0010, 16'h0000, 2'b11, 0);   // R11 contents unchanged
    do_txn(0, 16'h0200, 16'h0000, 2'b11, 0);   // R10 read then write
    do_txn(1, 16'h0200, 16'h5A5A, 2'b01, 1);   // R12 back to back
    do_txn(0, 16'h0200, 16'h0000, 2'b11, 1);
    do_txn(1, 16'hFFFF, 16'hC3C3, 2'b11, 0);   // address extremes
    do_txn(1, 16'h0000, 16'h3C3C, 2'b11, 1);
    do_txn(0, 16'hFFFF, 16'h0000, 2'b11, 0);
    do_txn(0, 16'h0000, 16'h0000, 2'b11, 1);
    do_txn(0, 16'h0000, 16'h0000, 2'b00, 1);   // R11 empty read

    lf = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_txn(lf[5], 16'hA000 | {13'b0, lf[2:0]}, lf ^ 16'h5A5A, lf[9:8], lf[11]);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule